// File: doc/BRIEF.md
# Transactional Speculation Tag Tracker

This block sits beside a private L1 data cache and adds hardware support for transactional execution. The core opens a transaction with a speculate command and ends it with commit or abort. While a transaction runs, every read hit marks its line with a speculative-read tag and every write hit marks it with a speculative-write tag. Two tag bits per line make up all of the speculation state. The next level of cache holds none.

The cache reports evictions and invalidations as a single-cycle strobe with a line index. If the line it names carries either tag, the transaction fails. The block then raises a sticky abort flag. It also pulses a discard vector that lists the lines holding speculative writes, so that the cache can invalidate them. No register state is saved or restored; software reads the flag and recovers. Function calls, TLB misses and any other events do not end a transaction.

Every input is a one-cycle strobe that is always accepted. There is no back-pressure, and no event is ever stalled or queued. All outputs are registered and change on the clock edge after the event that causes them.

Top module: `spec_tag_tracker`

## Requirements
- R1: After reset, txn_active, abort_flag, commit_done and drop_valid are 0, drop_mask is all zero and no line carries a tag.
- R2: A spec_cmd while no transaction runs sets txn_active on the next cycle and clears abort_flag.
- R3: During a transaction, an access with acc_valid=1, acc_hit=1, acc_write=0 tags line acc_idx as read. A later evict_valid for that index aborts the transaction.
- R4: During a transaction, a write hit (acc_write=1) tags the line as written. On abort, drop_mask bit i is 1 exactly for each line i that carries a write tag, so lines that are only read stay 0.
- R5: An eviction of a line with no tag leaves the transaction running and raises nothing.
- R6: Accesses made while no transaction runs, and accesses with acc_hit=0, set no tag.
- R7: A commit_cmd during a transaction clears every tag in one cycle, drops txn_active and pulses commit_done high for exactly one cycle.
- R8: If an abort cause (abort_cmd, or an eviction of a tagged line) arrives in the same cycle as commit_cmd, the abort wins: no commit_done, and the abort flag and discard pulse appear.
- R9: An abort_cmd during a transaction aborts it. An abort_cmd while idle has no effect.
- R10: abort_flag stays 1 until a spec_cmd or a clear_cmd arrives. An abort also clears all tags.
- R11: A spec_cmd while a transaction already runs is ignored: the transaction continues and keeps its tags.
- R12: drop_valid is high for exactly the one cycle in which abort_flag first rises after an abort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| spec_cmd | input | 1 | Begin-transaction strobe |
| commit_cmd | input | 1 | Commit strobe |
| abort_cmd | input | 1 | Software abort strobe |
| clear_cmd | input | 1 | Acknowledge and clear the abort flag |
| acc_valid | input | 1 | Cache access event strobe |
| acc_idx | input | IDX_W | Line index of the access |
| acc_write | input | 1 | 1 = write access, 0 = read access |
| acc_hit | input | 1 | Access hit in L1 |
| evict_valid | input | 1 | Eviction or invalidation strobe |
| evict_idx | input | IDX_W | Line index leaving L1 |
| txn_active | output | 1 | A transaction is running |
| abort_flag | output | 1 | Sticky flag: the last transaction aborted |
| commit_done | output | 1 | One-cycle pulse after a successful commit |
| drop_valid | output | 1 | One-cycle pulse: drop_mask is valid |
| drop_mask | output | NUM_LINES | Bit i = 1: line i held speculative write data and must be invalidated |

## Verification
The hardest situations to reach are the same-cycle races, where commit meets an abort command or meets the eviction of a line it tagged. A tag is also invisible at the ports until an eviction probes it. The stimulus therefore builds each tag set on purpose, fires commit together with the abort cause in one step, and then probes earlier tagged lines with evictions. An eviction that leaves the transaction running shows that a tag was never set or has been cleared.

// File: rtl/spec_tag_pkg.sv
package spec_tag_pkg;
  typedef enum logic [0:0] {
    TXN_IDLE = 1'b0,
    TXN_RUN  = 1'b1
  } txn_state_e;
endpackage

// File: rtl/spec_tag_array.sv
module spec_tag_array #(
  parameter int NUM_LINES = 64,
  parameter int IDX_W     = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr_all,
  input  logic                 set_en,
  input  logic                 set_wr,
  input  logic [IDX_W-1:0]     set_idx,
  input  logic [IDX_W-1:0]     probe_idx,
  output logic                 probe_tagged,
  output logic [NUM_LINES-1:0] wr_vec
);
  logic [NUM_LINES-1:0] rd_q;
  logic [NUM_LINES-1:0] wr_q;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (!rst_n || clr_all) begin
        rd_q[g] <= 1'b0;
        wr_q[g] <= 1'b0;
      end else if (set_en && set_idx == IDX_W'(g)) begin
        if (set_wr) wr_q[g] <= 1'b1;
        else        rd_q[g] <= 1'b1;
      end
    end
  end

  assign probe_tagged = rd_q[probe_idx] | wr_q[probe_idx];
  assign wr_vec       = wr_q;
endmodule

// File: rtl/spec_txn_ctrl.sv
module spec_txn_ctrl
  import spec_tag_pkg::*;
#(
  parameter int NUM_LINES = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 spec_cmd,
  input  logic                 commit_cmd,
  input  logic                 abort_cmd,
  input  logic                 clear_cmd,
  input  logic                 acc_valid,
  input  logic                 acc_hit,
  input  logic                 evict_valid,
  input  logic                 probe_tagged,
  input  logic [NUM_LINES-1:0] wr_vec,
  output logic                 clr_all,
  output logic                 set_en,
  output logic                 txn_active,
  output logic                 abort_flag,
  output logic                 commit_done,
  output logic                 drop_valid,
  output logic [NUM_LINES-1:0] drop_mask
);
  txn_state_e state_q;
  logic running, abort_now, commit_now, start_now;

  always_comb begin
    running    = (state_q == TXN_RUN);
    abort_now  = running && (abort_cmd || (evict_valid && probe_tagged));
    commit_now = running && commit_cmd && !abort_now;
    start_now  = !running && spec_cmd;
    clr_all    = abort_now || commit_now;
    set_en     = running && !clr_all && acc_valid && acc_hit;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= TXN_IDLE;
      abort_flag  <= 1'b0;
      commit_done <= 1'b0;
      drop_valid  <= 1'b0;
      drop_mask   <= '0;
    end else begin
      if (clr_all)        state_q <= TXN_IDLE;
      else if (start_now) state_q <= TXN_RUN;

      if (abort_now)                              abort_flag <= 1'b1;
      else if (start_now || (!running && clear_cmd)) abort_flag <= 1'b0;

      commit_done <= commit_now;
      drop_valid  <= abort_now;
      drop_mask   <= abort_now ? wr_vec : '0;
    end
  end

  assign txn_active = running;
endmodule

// File: rtl/spec_tag_tracker.sv
module spec_tag_tracker #(
  parameter int NUM_LINES = 64,
  localparam int IDX_W    = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 spec_cmd,
  input  logic                 commit_cmd,
  input  logic                 abort_cmd,
  input  logic                 clear_cmd,
  input  logic                 acc_valid,
  input  logic [IDX_W-1:0]     acc_idx,
  input  logic                 acc_write,
  input  logic                 acc_hit,
  input  logic                 evict_valid,
  input  logic [IDX_W-1:0]     evict_idx,
  output logic                 txn_active,
  output logic                 abort_flag,
  output logic                 commit_done,
  output logic                 drop_valid,
  output logic [NUM_LINES-1:0] drop_mask
);
  logic                 clr_all, set_en, probe_tagged;
  logic [NUM_LINES-1:0] wr_vec;

  spec_tag_array #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) tags_i (
    .clk(clk), .rst_n(rst_n), .clr_all(clr_all), .set_en(set_en),
    .set_wr(acc_write), .set_idx(acc_idx), .probe_idx(evict_idx),
    .probe_tagged(probe_tagged), .wr_vec(wr_vec)
  );

  spec_txn_ctrl #(.NUM_LINES(NUM_LINES)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .spec_cmd(spec_cmd), .commit_cmd(commit_cmd),
    .abort_cmd(abort_cmd), .clear_cmd(clear_cmd), .acc_valid(acc_valid),
    .acc_hit(acc_hit), .evict_valid(evict_valid), .probe_tagged(probe_tagged),
    .wr_vec(wr_vec), .clr_all(clr_all), .set_en(set_en),
    .txn_active(txn_active), .abort_flag(abort_flag),
    .commit_done(commit_done), .drop_valid(drop_valid), .drop_mask(drop_mask)
  );
endmodule

// File: rtl/spec_tag_chk.sv
module spec_tag_chk #(
  parameter int NUM_LINES = 64
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 spec_cmd,
  input logic                 commit_cmd,
  input logic                 abort_cmd,
  input logic                 clear_cmd,
  input logic                 evict_valid,
  input logic                 txn_active,
  input logic                 abort_flag,
  input logic                 commit_done,
  input logic                 drop_valid,
  input logic [NUM_LINES-1:0] drop_mask
);
  // R12
  drop_implies_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop_valid |-> abort_flag);

  // R8
  commit_abort_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(commit_done && drop_valid));

  // R7
  commit_ends_txn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_done |-> (!txn_active && $past(txn_active)));

  // R2
  start_clears_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(txn_active) |-> !abort_flag);

  // R10
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_flag && !spec_cmd && !clear_cmd) |=> abort_flag);

  // R11
  nested_spec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_active && spec_cmd && !commit_cmd && !abort_cmd && !evict_valid) |=> txn_active);

  // R9
  idle_no_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !txn_active |=> !drop_valid);

  // R4
  mask_only_on_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !drop_valid |-> (drop_mask == '0));
endmodule

bind spec_tag_tracker spec_tag_chk #(.NUM_LINES(NUM_LINES)) chk_i (
  .clk(clk), .rst_n(rst_n), .spec_cmd(spec_cmd), .commit_cmd(commit_cmd),
  .abort_cmd(abort_cmd), .clear_cmd(clear_cmd), .evict_valid(evict_valid),
  .txn_active(txn_active), .abort_flag(abort_flag), .commit_done(commit_done),
  .drop_valid(drop_valid), .drop_mask(drop_mask)
);

// File: tb/spec_tag_tracker_tb_top.sv
module spec_tag_tracker_tb_top;
  localparam int N  = 64;
  localparam int IW = $clog2(N);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic spec_cmd = 0, commit_cmd = 0, abort_cmd = 0, clear_cmd = 0;
  logic acc_valid = 0, acc_write = 0, acc_hit = 0, evict_valid = 0;
  logic [IW-1:0] acc_idx = '0, evict_idx = '0;
  logic txn_active, abort_flag, commit_done, drop_valid;
  logic [N-1:0] drop_mask;

  always #10 clk = ~clk;

  spec_tag_tracker #(.NUM_LINES(N)) dut_i (.*);

  typedef struct {
    logic         act;
    logic         flg;
    logic         cd;
    logic         dv;
    logic [N-1:0] msk;
    string        req;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Monitor: samples 5 ns after each rising edge and compares with the scoreboard.
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        checks++;
        if (txn_active !== e.act || abort_flag !== e.flg || commit_done !== e.cd ||
            drop_valid !== e.dv || drop_mask !== e.msk) begin
          errors++;
          $display("FAIL %s: got act=%b flg=%b cd=%b dv=%b mask=%h, exp act=%b flg=%b cd=%b dv=%b mask=%h",
                   e.req, txn_active, abort_flag, commit_done, drop_valid, drop_mask,
                   e.act, e.flg, e.cd, e.dv, e.msk);
        end
      end
    end
  end

  // cmd bits: {spec, commit, abort, clear}
  task automatic step(input logic [3:0] cmd,
                      input logic av, input int ai, input logic aw, input logic ah,
                      input logic ev, input int ei,
                      input logic e_act, input logic e_flg, input logic e_cd,
                      input logic e_dv, input logic [N-1:0] e_msk, input string req);
    exp_t e;
    @(negedge clk);
    {spec_cmd, commit_cmd, abort_cmd, clear_cmd} = cmd;
    acc_valid = av; acc_idx = IW'(ai); acc_write = aw; acc_hit = ah;
    evict_valid = ev; evict_idx = IW'(ei);
    e.act = e_act; e.flg = e_flg; e.cd = e_cd; e.dv = e_dv; e.msk = e_msk; e.req = req;
    exp_q.push_back(e);
  endtask

  function automatic logic [N-1:0] bit_at(input int i);
    return N'(1) << i;
  endfunction

  localparam logic [3:0] NONE = 4'b0000, SPEC = 4'b1000, COMMIT = 4'b0100,
                         ABORT = 4'b0010, CLEAR = 4'b0001;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step(NONE, 0,0,0,0, 0,0, 0,0,0,0,'0, "R1 reset state");
    step(NONE, 1,5,0,1, 0,0, 0,0,0,0,'0, "R6 access while idle");
    step(SPEC, 0,0,0,0, 0,0, 1,0,0,0,'0, "R2 start");
    step(NONE, 0,0,0,0, 1,5, 1,0,0,0,'0, "R6 idle access left no tag");
    step(NONE, 1,3,0,1, 0,0, 1,0,0,0,'0, "R3 read hit");
    step(NONE, 1,9,0,0, 0,0, 1,0,0,0,'0, "R6 read miss");
    step(NONE, 0,0,0,0, 1,9, 1,0,0,0,'0, "R6 miss left no tag");
    step(NONE, 0,0,0,0, 1,20, 1,0,0,0,'0, "R5 untagged evict");
    step(NONE, 0,0,0,0, 1,3, 0,1,0,1,'0, "R3 R4 read-tagged evict aborts, empty mask");
    step(NONE, 0,0,0,0, 0,0, 0,1,0,0,'0, "R10 R12 flag sticky, pulse ends");
    step(ABORT,0,0,0,0, 0,0, 0,1,0,0,'0, "R9 abort while idle ignored");
    step(CLEAR,0,0,0,0, 0,0, 0,0,0,0,'0, "R10 clear");
    step(SPEC, 0,0,0,0, 0,0, 1,0,0,0,'0, "R2 start");
    step(NONE, 1,7,1,1, 0,0, 1,0,0,0,'0, "R4 write hit");
    step(NONE, 1,63,1,1, 0,0, 1,0,0,0,'0, "R4 write hit top line");
    step(NONE, 1,2,0,1, 0,0, 1,0,0,0,'0, "R3 read hit");
    step(SPEC, 0,0,0,0, 0,0, 1,0,0,0,'0, "R11 nested spec ignored");
    step(NONE, 0,0,0,0, 1,7, 0,1,0,1, bit_at(7)|bit_at(63), "R4 R11 write lines dropped");
    step(SPEC, 0,0,0,0, 0,0, 1,0,0,0,'0, "R2 R10 spec clears flag");
    step(NONE, 0,0,0,0, 1,2, 1,0,0,0,'0, "R10 abort cleared tags");
    step(NONE, 1,7,1,1, 0,0, 1,0,0,0,'0, "R4 write hit");
    step(NONE, 1,4,0,1, 0,0, 1,0,0,0,'0, "R3 read hit");
    step(COMMIT,0,0,0,0,0,0, 0,0,1,0,'0, "R7 commit");
    step(NONE, 0,0,0,0, 0,0, 0,0,0,0,'0, "R7 commit pulse one cycle");
    step(SPEC, 0,0,0,0, 0,0, 1,0,0,0,'0, "R2 start");
    step(NONE, 0,0,0,0, 1,7, 1,0,0,0,'0, "R7 commit cleared write tag");
    step(NONE, 0,0,0,0, 1,4, 1,0,0,0,'0, "R7 commit cleared read tag");
    step(NONE, 1,10,1,1, 0,0, 1,0,0,0,'0, "R4 write hit");
    step(COMMIT|ABORT,0,0,0,0,0,0, 0,1,0,1, bit_at(10), "R8 abort cmd beats commit");
    step(SPEC, 0,0,0,0, 0,0, 1,0,0,0,'0, "R2 start");
    step(NONE, 1,11,1,1, 0,0, 1,0,0,0,'0, "R4 write hit");
    step(COMMIT,0,0,0,0,1,11, 0,1,0,1, bit_at(11), "R8 tagged evict beats commit");
    step(SPEC, 0,0,0,0, 0,0, 1,0,0,0,'0, "R2 start");
    step(NONE, 1,12,1,1, 0,0, 1,0,0,0,'0, "R4 write hit");
    step(ABORT,0,0,0,0, 0,0, 0,1,0,1, bit_at(12), "R9 software abort");
    step(SPEC, 0,0,0,0, 0,0, 1,0,0,0,'0, "R2 start");
    step(NONE, 0,0,0,0, 1,12, 1,0,0,0,'0, "R10 abort cleared tags");
    step(NONE, 0,0,0,0, 0,0, 1,0,0,0,'0, "R5 idle cycle in txn");
    @(negedge clk);
    {spec_cmd, commit_cmd, abort_cmd, clear_cmd} = NONE;
    acc_valid = 0; evict_valid = 0;
    wait (exp_q.size() == 0);
    @(negedge clk);
    done = 1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got hang, exp completion");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule